// File: doc/BRIEF.md
# Windowed Watchdog Timer with Grace Period

This block supervises software through a slow, free-running watchdog clock. A bus-side register file on the system clock holds the configuration. An 18-bit up counter in the watchdog clock domain advances on every watchdog clock edge while the block is enabled. When the count reaches the programmed power-of-two interval, the block raises a time-out flag, an optional interrupt and an optional wake-up pulse. It then opens a grace window of programmable length. If software does not write the reload key before that window closes and reset generation is enabled, the block raises a system reset request. The request stays high until the block itself is reset.

Enable, disable and reload commands cross into the watchdog domain through two-stage synchronizers. A busy bit shows when an enable change has not yet completed. Events from the watchdog domain return to the bus domain as toggle-synchronized pulses, so each event is counted exactly once. An unlock input gates every configuration field. The write-1-to-clear flags are not gated by it. A debug-halt input freezes the count unless a debug-override bit is set.

Top module: `wdog_window`

## Requirements
- R1: Control bits [10:8] select the time-out interval. Code k gives 2^(4+2k) watchdog clocks: 16, 64 and 256 up to 2^18. When the count reaches it, the time-out flag in control bit 3 is set.
- R2: `irq_o` is high exactly while both the time-out flag (bit 3) and the interrupt enable (bit 6) are set.
- R3: Writing exactly 0x00005AA5 to offset 0x8 restarts the count from zero. Any other value written there has no effect on the count.
- R4: Bits [1:0] of the register at offset 0x4 select the grace window after time-out: codes 0, 1, 2 and 3 give 1026, 130, 18 and 3 watchdog clocks.
- R5: If reset enable (control bit 1) is set and the grace window ends without a reload, `sys_rst_req_o` rises and the reset flag (control bit 2) is set. The request stays high until `rst_ni` is asserted.
- R6: A watchdog reset event returns the grace-window select at offset 0x4 to code 0.
- R7: Clearing the enable bit (control bit 7) stops the counter and zeroes it. Setting the bit again restarts the count from zero.
- R8: Control bit 30 is read-only. It reads 1 from the write that changes the enable bit until the change has reached the watchdog domain and come back, about two watchdog clocks.
- R9: When wake-up enable (bit 4) and interrupt enable (bit 6) are both set at a time-out, `wake_o` pulses for one bus clock and the wake flag (bit 5) is set.
- R10: While `dbg_halt_i` is high the count pauses, unless the debug-override bit (control bit 31) is set, in which case counting continues.
- R11: Bits 1, 4, 6, 7, 8 to 10 and 31 of the control register, and bits [1:0] at offset 0x4, change on a write only while `unlock_i` is high.
- R12: Writing 1 to bit 2, 3 or 5 of the control register clears that flag, whatever the state of `unlock_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| wclk_i | input | 1 | Slow watchdog clock |
| unlock_i | input | 1 | Allows configuration fields to be written |
| dbg_halt_i | input | 1 | Debug halt; pauses counting unless overridden |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW | Register byte offset (0x0, 0x4, 0x8) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Time-out interrupt |
| wake_o | output | 1 | One-cycle wake-up event |
| sys_rst_req_o | output | 1 | Sticky system reset request |

## Verification
Interval codes are drawn at random and paired with directed grace-window codes. For each one the bench samples the flag a little before and a little after the expected time-out. This separates a correct interval from one that is off by a power of two. Random wrong-key writes made in the middle of the interval show whether a non-key value restarts the count, because a wrongful restart delays the flag past its deadline. A correct key placed mid-interval shows the opposite. A disable/enable sequence, a halt with and without override, and locked versus unlocked writes each produce a distinct flag timing or read value that tells whether the counter was cleared, paused or left unchanged.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
   localparam logic [31:0] RELOAD_KEY = 32'h0000_5AA5;
   localparam int CTL_OFS = 0;
   localparam int ALT_OFS = 4;
   localparam int KEY_OFS = 8;
   localparam int TSEL_W  = 3;
   localparam int DSEL_W  = 2;
   // control field positions, shared by bus logic and checker
   localparam int B_RSTEN = 1;
   localparam int B_RSTF  = 2;
   localparam int B_TOF   = 3;
   localparam int B_WKEN  = 4;
   localparam int B_WKF   = 5;
   localparam int B_INTEN = 6;
   localparam int B_EN    = 7;
   localparam int B_TSEL  = 8;
   localparam int B_BUSY  = 30;
   localparam int B_OVR   = 31;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_GRACE = 2'd1,
      ST_DONE  = 2'd2
   } wdw_state_e;

   // grace window length in watchdog clocks for each select code
   function automatic int unsigned grace_len(input logic [DSEL_W-1:0] sel);
      case (sel)
         2'd0:    return 1026;
         2'd1:    return 130;
         2'd2:    return 18;
         default: return 3;
      endcase
   endfunction
endpackage

// File: rtl/wdw_sync.sv
module wdw_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("wdw_sync needs at least two stages");
      end
      if (W < 1) begin : g_bad_width
         $error("wdw_sync width must be positive");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wdw_evt_xfer.sv
module wdw_evt_xfer #(
   parameter int STAGES = 2
) (
   input  logic src_clk_i,
   input  logic dst_clk_i,
   input  logic rst_ni,
   input  logic pulse_i,
   output logic pulse_o
);
   logic tog_q, tog_s, seen_q;

   always_ff @(posedge src_clk_i or negedge rst_ni) begin
      if (!rst_ni)      tog_q <= 1'b0;
      else if (pulse_i) tog_q <= ~tog_q;
   end

   wdw_sync #(.W(1), .STAGES(STAGES)) u_sync (
      .clk_i (dst_clk_i),
      .rst_ni(rst_ni),
      .d_i   (tog_q),
      .q_o   (tog_s)
   );

   always_ff @(posedge dst_clk_i or negedge rst_ni) begin
      if (!rst_ni) seen_q <= 1'b0;
      else         seen_q <= tog_s;
   end

   assign pulse_o = tog_s ^ seen_q;
endmodule

// File: rtl/wdw_core.sv
module wdw_core
   import wdw_pkg::*;
#(
   parameter int CW      = 18,
   parameter int DW      = 11,
   parameter int IV_BASE = 4,
   parameter int IV_STEP = 2
) (
   input  logic              wclk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              halt_i,
   input  logic              ovr_i,
   input  logic              rsten_i,
   input  logic [TSEL_W-1:0] tsel_i,
   input  logic [DSEL_W-1:0] dsel_i,
   input  logic              rld_tog_i,
   output logic              tout_o,
   output logic              rstev_o
);
   localparam int MAX_EXP = IV_BASE + IV_STEP * ((1 << TSEL_W) - 1);

   generate
      if (CW < MAX_EXP) begin : g_bad_cw
         $error("counter too narrow for the longest interval");
      end
      if ((1 << DW) <= 1026) begin : g_bad_dw
         $error("grace counter too narrow for the longest window");
      end
   endgenerate

   wdw_state_e    st_q;
   logic [CW-1:0] cnt_q, lim_m1;
   logic [DW-1:0] dly_q, glen_m1;
   logic          rld_seen_q, rld_hit, tick;

   assign lim_m1  = CW'((64'd1 << (IV_BASE + IV_STEP * int'(tsel_i))) - 64'd1);
   assign glen_m1 = DW'(grace_len(dsel_i) - 1);
   assign rld_hit = rld_tog_i ^ rld_seen_q;
   assign tick    = en_i && (!halt_i || ovr_i);

   always_ff @(posedge wclk_i or negedge rst_ni) begin
      if (!rst_ni) rld_seen_q <= 1'b0;
      else         rld_seen_q <= rld_tog_i;
   end

   always_ff @(posedge wclk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q    <= ST_RUN;
         cnt_q   <= '0;
         dly_q   <= '0;
         tout_o  <= 1'b0;
         rstev_o <= 1'b0;
      end else begin
         tout_o  <= 1'b0;
         rstev_o <= 1'b0;
         if (!en_i || rld_hit) begin
            st_q  <= ST_RUN;
            cnt_q <= '0;
            dly_q <= '0;
         end else if (tick) begin
            case (st_q)
               ST_RUN: begin
                  if (cnt_q == lim_m1) begin
                     st_q   <= ST_GRACE;
                     tout_o <= 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_GRACE: begin
                  if (dly_q == glen_m1) begin
                     st_q    <= ST_DONE;
                     rstev_o <= rsten_i;
                  end else begin
                     dly_q <= dly_q + 1'b1;
                  end
               end
               default: st_q <= ST_DONE;
            endcase
         end
      end
   end
endmodule

// File: rtl/wdog_window.sv
module wdog_window
   import wdw_pkg::*;
#(
   parameter int CW          = 18,
   parameter int DW          = 11,
   parameter int IV_BASE     = 4,
   parameter int IV_STEP     = 2,
   parameter int SYNC_STAGES = 2,
   parameter int AW          = 4
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          wclk_i,
   input  logic          unlock_i,
   input  logic          dbg_halt_i,
   input  logic          wr_en_i,
   input  logic [AW-1:0] addr_i,
   input  logic [31:0]   wdata_i,
   output logic [31:0]   rdata_o,
   output logic          irq_o,
   output logic          wake_o,
   output logic          sys_rst_req_o
);
   localparam int CFG_W = 1 + 1 + 1 + 1 + TSEL_W + DSEL_W + 1;

   generate
      if (AW < 4) begin : g_bad_aw
         $error("address too narrow for the key offset");
      end
   endgenerate

   logic              rsten_q, wken_q, inten_q, en_q, ovr_q;
   logic [TSEL_W-1:0] tsel_q;
   logic [DSEL_W-1:0] dsel_q;
   logic              rstf_q, tof_q, wkf_q, rld_tog;
   logic              wr_ctl, wr_alt, wr_key;
   logic              tout_w, rstev_w, tout_p, rstev_p;
   logic              en_back, busy;
   logic [CFG_W-1:0]  cfg_b, cfg_w;
   logic              en_w, halt_w, ovr_w, rsten_w, rld_w;
   logic [TSEL_W-1:0] tsel_w;
   logic [DSEL_W-1:0] dsel_w;
   logic [31:0]       ctl_rd;
   wire unused_wdata = &{1'b0, wdata_i[30:11], wdata_i[0]};

   assign wr_ctl = wr_en_i && (addr_i == AW'(CTL_OFS));
   assign wr_alt = wr_en_i && (addr_i == AW'(ALT_OFS));
   assign wr_key = wr_en_i && (addr_i == AW'(KEY_OFS));

   // bus domain register file
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rsten_q   <= 1'b0;
         wken_q    <= 1'b0;
         inten_q   <= 1'b0;
         en_q      <= 1'b0;
         ovr_q     <= 1'b0;
         tsel_q    <= '0;
         dsel_q    <= '0;
         rstf_q    <= 1'b0;
         tof_q     <= 1'b0;
         wkf_q     <= 1'b0;
         rld_tog   <= 1'b0;
         wake_o    <= 1'b0;
         sys_rst_req_o <= 1'b0;
      end else begin
         wake_o <= 1'b0;
         if (wr_ctl) begin
            if (unlock_i) begin
               rsten_q <= wdata_i[B_RSTEN];
               wken_q  <= wdata_i[B_WKEN];
               inten_q <= wdata_i[B_INTEN];
               en_q    <= wdata_i[B_EN];
               tsel_q  <= wdata_i[B_TSEL +: TSEL_W];
               ovr_q   <= wdata_i[B_OVR];
            end
            if (wdata_i[B_RSTF]) rstf_q <= 1'b0;
            if (wdata_i[B_TOF])  tof_q  <= 1'b0;
            if (wdata_i[B_WKF])  wkf_q  <= 1'b0;
         end
         if (wr_alt && unlock_i) dsel_q <= wdata_i[DSEL_W-1:0];
         if (wr_key && (wdata_i == RELOAD_KEY)) rld_tog <= ~rld_tog;
         // events win over a same-cycle clear
         if (tout_p) begin
            tof_q <= 1'b1;
            if (wken_q && inten_q) begin
               wkf_q  <= 1'b1;
               wake_o <= 1'b1;
            end
         end
         if (rstev_p) begin
            rstf_q        <= 1'b1;
            dsel_q        <= '0;
            sys_rst_req_o <= 1'b1;
         end
      end
   end

   // configuration into the watchdog domain
   assign cfg_b = {rld_tog, dbg_halt_i, ovr_q, rsten_q, en_q, tsel_q, dsel_q};

   wdw_sync #(.W(CFG_W), .STAGES(SYNC_STAGES)) u_cfg_sync (
      .clk_i (wclk_i),
      .rst_ni(rst_ni),
      .d_i   (cfg_b),
      .q_o   (cfg_w)
   );

   assign {rld_w, halt_w, ovr_w, rsten_w, en_w, tsel_w, dsel_w} = cfg_w;

   // enable acknowledge back to the bus domain for the busy flag
   wdw_sync #(.W(1), .STAGES(SYNC_STAGES)) u_en_back (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (en_w),
      .q_o   (en_back)
   );

   assign busy = en_q ^ en_back;

   wdw_core #(
      .CW(CW), .DW(DW), .IV_BASE(IV_BASE), .IV_STEP(IV_STEP)
   ) u_core (
      .wclk_i   (wclk_i),
      .rst_ni   (rst_ni),
      .en_i     (en_w),
      .halt_i   (halt_w),
      .ovr_i    (ovr_w),
      .rsten_i  (rsten_w),
      .tsel_i   (tsel_w),
      .dsel_i   (dsel_w),
      .rld_tog_i(rld_w),
      .tout_o   (tout_w),
      .rstev_o  (rstev_w)
   );

   wdw_evt_xfer #(.STAGES(SYNC_STAGES)) u_tout_xfer (
      .src_clk_i(wclk_i),
      .dst_clk_i(clk_i),
      .rst_ni   (rst_ni),
      .pulse_i  (tout_w),
      .pulse_o  (tout_p)
   );

   wdw_evt_xfer #(.STAGES(SYNC_STAGES)) u_rst_xfer (
      .src_clk_i(wclk_i),
      .dst_clk_i(clk_i),
      .rst_ni   (rst_ni),
      .pulse_i  (rstev_w),
      .pulse_o  (rstev_p)
   );

   always_comb begin
      ctl_rd                       = '0;
      ctl_rd[B_RSTEN]              = rsten_q;
      ctl_rd[B_RSTF]               = rstf_q;
      ctl_rd[B_TOF]                = tof_q;
      ctl_rd[B_WKEN]               = wken_q;
      ctl_rd[B_WKF]                = wkf_q;
      ctl_rd[B_INTEN]              = inten_q;
      ctl_rd[B_EN]                 = en_q;
      ctl_rd[B_TSEL +: TSEL_W]     = tsel_q;
      ctl_rd[B_BUSY]               = busy;
      ctl_rd[B_OVR]                = ovr_q;
   end

   always_comb begin
      case (addr_i)
         AW'(CTL_OFS): rdata_o = ctl_rd;
         AW'(ALT_OFS): rdata_o = {{(32-DSEL_W){1'b0}}, dsel_q};
         default:      rdata_o = '0;
      endcase
   end

   assign irq_o = tof_q && inten_q;
endmodule

// File: rtl/wdw_checker.sv
module wdw_checker
   import wdw_pkg::*;
#(
   parameter int AW = 4
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              wr_en_i,
   input logic              unlock_i,
   input logic [AW-1:0]     addr_i,
   input logic [31:0]       wdata_i,
   input logic              en_q,
   input logic              busy,
   input logic              rld_tog,
   input logic [DSEL_W-1:0] dsel_q,
   input logic              wkf_q,
   input logic              wake_o,
   input logic              sys_rst_req_o
);
   AST_RST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$fell(sys_rst_req_o)); // R5

   AST_DSEL_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sys_rst_req_o) |-> (dsel_q == '0)); // R6

   AST_BAD_KEY_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == AW'(KEY_OFS) && wdata_i != RELOAD_KEY) |=> $stable(rld_tog)); // R3

   AST_GOOD_KEY_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == AW'(KEY_OFS) && wdata_i == RELOAD_KEY) |=> !$stable(rld_tog)); // R3

   AST_LOCKED_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == AW'(CTL_OFS) && !unlock_i) |=> $stable(en_q)); // R11

   AST_BUSY_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && unlock_i && addr_i == AW'(CTL_OFS) && wdata_i[B_EN] != en_q) |=> busy); // R8

   AST_WAKE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_o |-> wkf_q); // R9
endmodule

bind wdog_window wdw_checker #(.AW(AW)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .wr_en_i      (wr_en_i),
   .unlock_i     (unlock_i),
   .addr_i       (addr_i),
   .wdata_i      (wdata_i),
   .en_q         (en_q),
   .busy         (busy),
   .rld_tog      (rld_tog),
   .dsel_q       (dsel_q),
   .wkf_q        (wkf_q),
   .wake_o       (wake_o),
   .sys_rst_req_o(sys_rst_req_o)
);

// File: tb/wdog_window_test.sv
module wdog_window_test;
   localparam logic [31:0] KEY = 32'h0000_5AA5;
   localparam int WPER = 5; // bus clocks per watchdog clock

   logic        clk = 1'b0, wclk = 1'b0, rst_n = 1'b0;
   logic        unlock = 1'b0, halt = 1'b0, wr_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0, rdata;
   logic        irq, wake, rreq;
   int          n_tests = 0, n_fail = 0, wake_cnt = 0;

   always #4 clk = ~clk;
   always #20 wclk = ~wclk;

   wdog_window uut (
      .clk_i(clk), .rst_ni(rst_n), .wclk_i(wclk), .unlock_i(unlock),
      .dbg_halt_i(halt), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
      .rdata_o(rdata), .irq_o(irq), .wake_o(wake), .sys_rst_req_o(rreq)
   );

   always @(posedge clk) if (wake) wake_cnt <= wake_cnt + 1;

   // control word: bit1 reset en, bit4 wake en, bit6 int en, bit7 enable,
   // bits[10:8] interval, bit31 override, plus W1C bits 2/3/5
   function automatic logic [31:0] ctlw(bit en, bit inten, bit wken, bit rsten,
                                        bit ovr, logic [2:0] ts, logic [2:0] w1c);
      return {ovr, 20'd0, ts, en, inten, w1c[2], wken, w1c[1], w1c[0], rsten, 1'b0};
   endfunction

   function automatic int exp_interval(int code);
      return 1 << (4 + 2 * code);
   endfunction

   task automatic wr(input logic [3:0] a, input logic [31:0] d, input bit unl);
      @(negedge clk);
      addr = a; wdata = d; unlock = unl; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; unlock = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic wwait(input int n);
      repeat (n * WPER) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input logic [31:0] got,
                      input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic chk_bit(input string req, input logic [3:0] a, input int b,
                          input bit exp);
      logic [31:0] r;
      rd(a, r);
      chk(r[b] == exp, req, 32'(r[b]), 32'(exp));
   endtask

   task automatic do_reset;
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      logic [31:0] r;
      int          w0;
      void'($urandom(32'd1234));
      do_reset();

      // reset state
      rd(4'h0, r); chk(r == 32'h0, "R11 reset ctl", r, 32'h0);
      rd(4'h4, r); chk(r == 32'h0, "R4 reset alt", r, 32'h0);
      chk(!irq && !rreq && !wake, "R5 reset outputs", {irq, rreq, wake}, 0);

      // locked write has no effect
      wr(4'h0, ctlw(1, 1, 1, 1, 1, 3'd5, 3'd0), 1'b0);
      wr(4'h4, 32'h3, 1'b0);
      rd(4'h0, r); chk(r == 32'h0, "R11 locked ctl", r, 32'h0);
      rd(4'h4, r); chk(r == 32'h0, "R11 locked alt", r, 32'h0);

      // enable, interval code 0
      wr(4'h0, ctlw(1, 1, 0, 0, 0, 3'd0, 3'd0), 1'b1);
      chk_bit("R8 busy after enable", 4'h0, 30, 1'b1);
      wwait(14);
      chk_bit("R1 code0 early", 4'h0, 3, 1'b0);
      wwait(11);
      chk_bit("R1 code0 late", 4'h0, 3, 1'b1);
      chk_bit("R8 busy settled", 4'h0, 30, 1'b0);
      chk(irq == 1'b1, "R2 irq with enable", 32'(irq), 1);

      // W1C while locked clears flag, keeps enable
      wr(4'h0, 32'h8, 1'b0);
      chk_bit("R12 flag cleared locked", 4'h0, 3, 1'b0);
      chk_bit("R11 enable kept", 4'h0, 7, 1'b1);
      chk(irq == 1'b0, "R2 irq after clear", 32'(irq), 0);

      // interrupt disabled: flag set, irq low
      wr(4'h0, ctlw(1, 0, 0, 0, 0, 3'd0, 3'd2), 1'b1);
      wr(4'h8, KEY, 1'b0);
      wwait(25);
      chk_bit("R1 flag without inten", 4'h0, 3, 1'b1);
      chk(irq == 1'b0, "R2 irq masked", 32'(irq), 0);

      // random interval codes
      for (int it = 0; it < 4; it++) begin
         int code = (it == 0) ? 2 : int'($urandom_range(0, 2));
         int lim = exp_interval(code);
         wr(4'h0, ctlw(1, 1, 0, 0, 0, 3'(code), 3'd2), 1'b1);
         wr(4'h8, KEY, 1'b0);
         wwait(lim - 2);
         chk_bit($sformatf("R1 code%0d early", code), 4'h0, 3, 1'b0);
         wwait(10);
         chk_bit($sformatf("R1 code%0d late", code), 4'h0, 3, 1'b1);
      end

      // wrong keys ignored, right key restarts (interval 64)
      for (int it = 0; it < 3; it++) begin
         logic [31:0] bad = $urandom();
         if (bad == KEY) bad = bad ^ 32'h1;
         wr(4'h0, ctlw(1, 1, 0, 0, 0, 3'd1, 3'd2), 1'b1);
         wr(4'h8, KEY, 1'b0);
         wwait(20);
         wr(4'h8, bad, 1'b0);
         wwait(58);
         chk_bit("R3 wrong key ignored", 4'h0, 3, 1'b1);
      end
      wr(4'h0, ctlw(1, 1, 0, 0, 0, 3'd1, 3'd2), 1'b1);
      wr(4'h8, KEY, 1'b0);
      wwait(40);
      wr(4'h8, KEY, 1'b0);
      wwait(38);
      chk_bit("R3 key restarts", 4'h0, 3, 1'b0);
      wwait(40);
      chk_bit("R3 key restart expires", 4'h0, 3, 1'b1);

      // debug halt, then override
      halt = 1'b1;
      wr(4'h0, ctlw(1, 1, 0, 0, 0, 3'd1, 3'd2), 1'b1);
      wr(4'h8, KEY, 1'b0);
      wwait(100);
      chk_bit("R10 halt pauses", 4'h0, 3, 1'b0);
      wr(4'h0, ctlw(1, 1, 0, 0, 1, 3'd1, 3'd0), 1'b1);
      wwait(85);
      chk_bit("R10 override counts", 4'h0, 3, 1'b1);
      halt = 1'b0;

      // wake-up event
      wr(4'h0, ctlw(1, 1, 1, 0, 0, 3'd0, 3'd2), 1'b1);
      wr(4'h8, KEY, 1'b0);
      w0 = wake_cnt;
      wwait(25);
      chk(wake_cnt == w0 + 1, "R9 one wake pulse", 32'(wake_cnt - w0), 1);
      chk_bit("R9 wake flag", 4'h0, 5, 1'b1);
      wr(4'h0, 32'h20, 1'b0);
      chk_bit("R12 wake flag cleared", 4'h0, 5, 1'b0);

      // grace window code 3 then reset request
      wr(4'h4, 32'h3, 1'b1);
      rd(4'h4, r); chk(r == 32'h3, "R11 alt unlocked", r, 32'h3);
      wr(4'h0, ctlw(1, 1, 0, 1, 0, 3'd0, 3'd2), 1'b1);
      wr(4'h8, KEY, 1'b0);
      wwait(34);
      chk(rreq == 1'b1, "R5 reset request", 32'(rreq), 1);
      chk_bit("R5 reset flag", 4'h0, 2, 1'b1);
      rd(4'h4, r); chk(r == 32'h0, "R6 grace select zeroed", r, 32'h0);
      wr(4'h0, 32'h4, 1'b0);
      chk_bit("R12 reset flag cleared", 4'h0, 2, 1'b0);
      wwait(20);
      chk(rreq == 1'b1, "R5 request held", 32'(rreq), 1);
      do_reset();
      chk(rreq == 1'b0, "R5 cleared by reset", 32'(rreq), 0);

      // grace window code 2 (18 clocks)
      wr(4'h4, 32'h2, 1'b1);
      wr(4'h0, ctlw(1, 1, 0, 1, 0, 3'd0, 3'd0), 1'b1);
      wwait(30);
      chk(rreq == 1'b0, "R4 code2 early", 32'(rreq), 0);
      wwait(20);
      chk(rreq == 1'b1, "R4 code2 late", 32'(rreq), 1);
      do_reset();

      // disable clears the count
      wr(4'h0, ctlw(1, 1, 0, 0, 0, 3'd0, 3'd0), 1'b1);
      wwait(10);
      wr(4'h0, ctlw(0, 1, 0, 0, 0, 3'd0, 3'd0), 1'b1);
      chk_bit("R8 busy after disable", 4'h0, 30, 1'b1);
      wwait(10);
      wr(4'h0, ctlw(1, 1, 0, 0, 0, 3'd0, 3'd0), 1'b1);
      wwait(15);
      chk_bit("R7 count restarted", 4'h0, 3, 1'b0);
      wwait(10);
      chk_bit("R7 count expires", 4'h0, 3, 1'b1);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule